// File: doc/BRIEF.md
# Point-to-Point Link Session Controller

This block is the protocol state machine for a two-node packet radio link that carries video. Once the user has picked a role (master or slave), the controller runs a fixed four-message handshake with the far node. It then settles into strict turn-taking: the master sends one data packet and waits for one in return, and the slave does the mirror image of that. The block drives a packet transceiver through a send request with a packet type and a sender-role bit. It is told of completed sends and of received packets. It asks a payload source for fresh data before each new data send.

A receive watchdog measures the time spent waiting for the expected packet. When that wait runs out, the master sends its last packet again and the slave simply keeps listening. Each expiry counts as a loss. A run of consecutive losses moves the controller into a Dead state, and only reset leaves it. A 4-bit status code reports the controller's condition to an on-screen display.

Top module: `link_session_ctrl`

## Requirements
- R1: After reset `status` is 0, and `tx_req` and `pay_req` are low. The controller stays in this state, ignoring received packets, until `role_pick` is high for a cycle. On that cycle `role_is_master` (1 = master, 0 = slave) is latched.
- R2: Packet types on `tx_type`/`rx_type` are 0 = seek, 1 = acknowledge, 2 = ready, 3 = data. The role bit (1 = master) tells the two ready packets apart. A master sends seek, waits for acknowledge, sends ready, then waits for the slave's ready.
- R3: A slave waits for seek, sends acknowledge, waits for the master's ready, then sends its own ready.
- R4: `tx_req` stays high, with `tx_type` and `tx_role` unchanged, until `tx_done` is sampled high. In the cycle after that it is low.
- R5: After the handshake a master repeats the cycle send data, then receive data. A slave repeats receive data, then send data.
- R6: Before each new data send, `pay_req` rises and `tx_req` stays low until `pay_valid` is sampled high. `tx_req` with type 3 follows in the next cycle.
- R7: A received packet counts only when the controller is waiting, its type is the expected one and its role bit is the opposite of the node's own role. Any other received packet changes nothing and does not restart the wait timer.
- R8: If the expected packet has not arrived after TIMEOUT_CYC cycles of waiting, a master raises `tx_req` again with the same packet, without asking for a payload. A slave keeps waiting and its timer restarts.
- R9: After MAX_LOSS consecutive timeouts, `status` becomes 15 and `tx_req` and `pay_req` drop. The controller then ignores every input until reset.
- R10: Each accepted packet clears the count of consecutive timeouts.
- R11: If the expected packet arrives in the same cycle as the timer expires, the packet is accepted and no timeout is counted.
- R12: `status` codes:
  - 1 to 4: sending seek, acknowledge, master ready or slave ready.
  - 5: master waiting during the handshake. 6: slave waiting during the handshake.
  - 8: master fetching or sending data. 9: master receiving data.
  - 10: slave fetching or sending data. 11: slave receiving data.
- R13: `role_pick` has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_pick | input | 1 | User role selection strobe |
| role_is_master | input | 1 | Selected role, 1 = master |
| tx_req | output | 1 | Send request to the transceiver |
| tx_type | output | 2 | Type of packet to send |
| tx_role | output | 1 | Sender role bit sent with the packet |
| tx_done | input | 1 | Transceiver finished the send |
| rx_valid | input | 1 | A packet was received this cycle |
| rx_type | input | 2 | Type of the received packet |
| rx_role | input | 1 | Sender role bit of the received packet |
| pay_req | output | 1 | Request for a new data payload |
| pay_valid | input | 1 | Payload source has a packet ready |
| status | output | 4 | Display status code |

## Verification
The wait timer's expiry and the arrival of the expected packet can land on the same clock edge. The bench provokes this by presenting the acknowledge in exactly the cycle the master's timer reaches its limit. It then judges the outcome by the next send request: it must carry the ready type and not a repeated seek. A second collision, between a discarded packet and a timer that is about to expire, is judged by the resend arriving on the unchanged cycle count.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   typedef enum logic [1:0] {
      PKT_SEEK  = 2'd0,
      PKT_ACK   = 2'd1,
      PKT_READY = 2'd2,
      PKT_DATA  = 2'd3
   } pkt_t;

   typedef enum logic [2:0] {
      CT_IDLE,
      CT_SEND,
      CT_LISTEN,
      CT_FETCH,
      CT_DEAD
   } ctl_t;

   localparam int          STEP_W     = 3;
   localparam logic [2:0]  STEP_DATA0 = 3'd4;
   localparam logic [2:0]  STEP_LAST  = 3'd5;

   localparam logic [3:0]  SC_IDLE      = 4'h0;
   localparam logic [3:0]  SC_M_HS_WAIT = 4'h5;
   localparam logic [3:0]  SC_S_HS_WAIT = 4'h6;
   localparam logic [3:0]  SC_M_DATA_TX = 4'h8;
   localparam logic [3:0]  SC_M_DATA_RX = 4'h9;
   localparam logic [3:0]  SC_S_DATA_TX = 4'hA;
   localparam logic [3:0]  SC_S_DATA_RX = 4'hB;
   localparam logic [3:0]  SC_DEAD      = 4'hF;

   // packet exchanged in a given step of the session
   function automatic pkt_t step_pkt(input logic [STEP_W-1:0] st);
      if (st >= STEP_DATA0)  return PKT_DATA;
      else if (st >= 3'd2)   return PKT_READY;
      else if (st == 3'd1)   return PKT_ACK;
      else                   return PKT_SEEK;
   endfunction

   // master transmits on even steps, slave on odd steps
   function automatic logic step_sends(input logic [STEP_W-1:0] st, input logic master);
      return st[0] ^ master;
   endfunction

endpackage

// File: rtl/lsc_wait_timer.sv
module lsc_wait_timer #(
   parameter int TIMEOUT_CYC = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic expire
);
   localparam int             TW   = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [TW-1:0]  LIMIT = TW'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("TIMEOUT_CYC must be at least 2");
   end

   logic [TW-1:0] tick_q;

   assign expire = run && (tick_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        tick_q <= '0;
      else if (!run || restart || expire) tick_q <= '0;
      else                                tick_q <= tick_q + 1'b1;
   end

   AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q <= LIMIT);                                          // R8
   AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (tick_q == '0));                                  // R8
endmodule

// File: rtl/lsc_loss_counter.sv
module lsc_loss_counter #(
   parameter int MAX_LOSS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic miss,
   input  logic hit,
   output logic fatal
);
   localparam int            LW   = $clog2(MAX_LOSS + 1);
   localparam logic [LW-1:0] LAST = LW'(MAX_LOSS - 1);

   if (MAX_LOSS < 1) begin : g_bad_loss
      $error("MAX_LOSS must be at least 1");
   end

   logic [LW-1:0] miss_q;

   assign fatal = miss && !hit && (miss_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              miss_q <= '0;
      else if (hit)            miss_q <= '0;
      else if (miss && !fatal) miss_q <= miss_q + 1'b1;
   end

   AST_LOSS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q <= LAST);                                           // R9
   AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (miss_q == '0));                                   // R10
endmodule

// File: rtl/lsc_status_enc.sv
module lsc_status_enc
   import lsc_pkg::*;
#(
   parameter bit STATUS_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  logic [STEP_W-1:0] step,
   input  logic              master,
   output logic [3:0]        code
);
   logic [3:0] code_c;
   logic       data_ph;

   assign data_ph = (step >= STEP_DATA0);

   always_comb begin
      code_c = SC_IDLE;
      unique case (ctl)
         CT_IDLE:   code_c = SC_IDLE;
         CT_DEAD:   code_c = SC_DEAD;
         CT_LISTEN: begin
            if (data_ph) code_c = master ? SC_M_DATA_RX : SC_S_DATA_RX;
            else         code_c = master ? SC_M_HS_WAIT : SC_S_HS_WAIT;
         end
         CT_SEND, CT_FETCH: begin
            if (data_ph) code_c = master ? SC_M_DATA_TX : SC_S_DATA_TX;
            else         code_c = 4'(step) + 4'd1;
         end
         default:   code_c = SC_IDLE;
      endcase
   end

   if (STATUS_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) code <= SC_IDLE;
         else        code <= code_c;
      end
   end else begin : g_comb
      assign code = code_c;
   end
endmodule

// File: rtl/link_session_ctrl.sv
module link_session_ctrl
   import lsc_pkg::*;
#(
   parameter int TIMEOUT_CYC = 1000000,
   parameter int MAX_LOSS    = 8,
   parameter bit STATUS_REG  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       role_pick,
   input  logic       role_is_master,
   output logic       tx_req,
   output logic [1:0] tx_type,
   output logic       tx_role,
   input  logic       tx_done,
   input  logic       rx_valid,
   input  logic [1:0] rx_type,
   input  logic       rx_role,
   output logic       pay_req,
   input  logic       pay_valid,
   output logic [3:0] status
);
   ctl_t              ctl_q, ctl_d;
   logic [STEP_W-1:0] step_q, step_d, step_nx;
   logic              master_q, master_d;
   logic              rx_hit, expire, fatal, listening;

   assign listening = (ctl_q == CT_LISTEN);
   assign rx_hit    = listening && rx_valid && (rx_type == step_pkt(step_q))
                      && (rx_role == !master_q);
   assign step_nx   = (step_q == STEP_LAST) ? STEP_DATA0 : step_q + 1'b1;

   lsc_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n), .run(listening), .restart(rx_hit), .expire(expire)
   );

   lsc_loss_counter #(.MAX_LOSS(MAX_LOSS)) i_loss (
      .clk(clk), .rst_n(rst_n), .miss(expire), .hit(rx_hit), .fatal(fatal)
   );

   lsc_status_enc #(.STATUS_REG(STATUS_REG)) i_status (
      .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .step(step_q), .master(master_q), .code(status)
   );

   always_comb begin
      ctl_d    = ctl_q;
      step_d   = step_q;
      master_d = master_q;
      unique case (ctl_q)
         CT_IDLE: if (role_pick) begin
            master_d = role_is_master;
            step_d   = '0;
            ctl_d    = role_is_master ? CT_SEND : CT_LISTEN;
         end
         CT_FETCH: if (pay_valid) ctl_d = CT_SEND;
         CT_SEND: if (tx_done) begin
            step_d = step_nx;
            ctl_d  = step_sends(step_nx, master_q)
                     ? ((step_nx >= STEP_DATA0) ? CT_FETCH : CT_SEND) : CT_LISTEN;
         end
         CT_LISTEN: begin
            if (rx_hit) begin
               step_d = step_nx;
               ctl_d  = step_sends(step_nx, master_q)
                        ? ((step_nx >= STEP_DATA0) ? CT_FETCH : CT_SEND) : CT_LISTEN;
            end else if (fatal) begin
               ctl_d = CT_DEAD;
            end else if (expire && master_q) begin
               step_d = step_q - 1'b1;
               ctl_d  = CT_SEND;
            end
         end
         CT_DEAD: ctl_d = CT_DEAD;
         default: ctl_d = CT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= CT_IDLE;
         step_q   <= '0;
         master_q <= 1'b0;
      end else begin
         ctl_q    <= ctl_d;
         step_q   <= step_d;
         master_q <= master_d;
      end
   end

   assign tx_req  = (ctl_q == CT_SEND);
   assign pay_req = (ctl_q == CT_FETCH);
   assign tx_type = step_pkt(step_q);
   assign tx_role = master_q;

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && !tx_done |=> tx_req && $stable(tx_type) && $stable(tx_role));   // R4
   AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_done |=> !tx_req);                                           // R4
   AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_req && pay_req));                                                    // R6
   AST_PAY_TO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      pay_req && pay_valid |=> tx_req && (tx_type == 2'd3));                    // R6
   AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 4'hF) |=> (status == 4'hF) && !tx_req && !pay_req);            // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q == CT_IDLE) |-> !tx_req && !pay_req);                              // R1
endmodule

// File: tb/test_link_session_ctrl.sv
module test_link_session_ctrl;
   localparam int TO   = 20;
   localparam int LOSS = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       role_pick = 1'b0, role_is_master = 1'b0;
   logic       tx_done = 1'b0, rx_valid = 1'b0, rx_role = 1'b0, pay_valid = 1'b0;
   logic [1:0] rx_type = 2'd0;
   logic       tx_req, tx_role, pay_req;
   logic [1:0] tx_type;
   logic [3:0] status;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   link_session_ctrl #(.TIMEOUT_CYC(TO), .MAX_LOSS(LOSS)) i_link_session_ctrl (
      .clk(clk), .rst_n(rst_n), .role_pick(role_pick), .role_is_master(role_is_master),
      .tx_req(tx_req), .tx_type(tx_type), .tx_role(tx_role), .tx_done(tx_done),
      .rx_valid(rx_valid), .rx_type(rx_type), .rx_role(rx_role),
      .pay_req(pay_req), .pay_valid(pay_valid), .status(status)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      role_pick = 0; tx_done = 0; rx_valid = 0; pay_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pick(input logic m);
      role_is_master = m; role_pick = 1'b1;
      @(negedge clk);
      role_pick = 1'b0;
   endtask

   task automatic rx_pkt(input logic [1:0] ty, input logic rl);
      rx_valid = 1'b1; rx_type = ty; rx_role = rl;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   // wait for a send request, check it, hold it, then complete it
   task automatic send_ok(input logic [1:0] ty, input logic rl, input logic [3:0] st,
                          input int hold, input string req);
      int n = 0;
      while (!tx_req && n < 100) begin @(negedge clk); n++; end
      chk(tx_req == 1'b1, req, tx_req, 1);
      chk(tx_type == ty, req, tx_type, ty);
      chk(tx_role == rl, req, tx_role, rl);
      chk(status == st, "R12", status, st);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(tx_req && tx_type == ty, "R4", tx_req, 1);
      end
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      chk(tx_req == 1'b0, "R4", tx_req, 0);
   endtask

   task automatic pay_ok(input int hold, input logic [3:0] st);
      int n = 0;
      while (!pay_req && n < 100) begin @(negedge clk); n++; end
      chk(pay_req == 1'b1, "R6", pay_req, 1);
      chk(status == st, "R12", status, st);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(pay_req && !tx_req, "R6", tx_req, 0);
      end
      pay_valid = 1'b1;
      @(negedge clk);
      pay_valid = 1'b0;
      chk(tx_req && !pay_req && tx_type == 2'd3, "R6", tx_req, 1);
   endtask

   // called right after a send completed: expect a resend exactly TO cycles later
   task automatic expect_resend(input logic [1:0] ty, input string req);
      repeat (TO - 1) @(negedge clk);
      chk(tx_req == 1'b0, req, tx_req, 0);
      @(negedge clk);
      chk(tx_req == 1'b1, req, tx_req, 1);
      chk(tx_type == ty, req, tx_type, ty);
      chk(pay_req == 1'b0, req, pay_req, 0);
   endtask

   task automatic t_reset_idle();
      do_reset();
      chk(status == 4'h0, "R1", status, 0);
      chk(!tx_req && !pay_req, "R1", tx_req, 0);
      rx_pkt(2'd0, 1'b1);
      repeat (5) @(negedge clk);
      chk(status == 4'h0 && !tx_req, "R1", status, 0);
   endtask

   task automatic t_master();
      do_reset();
      pick(1'b1);
      send_ok(2'd0, 1'b1, 4'h1, 3, "R2");
      chk(status == 4'h5, "R12", status, 5);
      pick(1'b0);
      chk(status == 4'h5, "R13", status, 5);
      rx_pkt(2'd1, 1'b0);
      send_ok(2'd2, 1'b1, 4'h3, 0, "R2");
      rx_pkt(2'd2, 1'b0);
      for (int k = 0; k < 3; k++) begin
         pay_ok(k, 4'h8);
         send_ok(2'd3, 1'b1, 4'h8, k, "R5");
         chk(status == 4'h9, "R5", status, 9);
         rx_pkt(2'd3, 1'b0);
      end
   endtask

   task automatic t_slave();
      do_reset();
      pick(1'b0);
      chk(status == 4'h6 && !tx_req, "R3", status, 6);
      rx_pkt(2'd0, 1'b1);
      send_ok(2'd1, 1'b0, 4'h2, 1, "R3");
      rx_pkt(2'd2, 1'b1);
      send_ok(2'd2, 1'b0, 4'h4, 0, "R3");
      for (int k = 0; k < 3; k++) begin
         chk(status == 4'hB && !pay_req, "R5", status, 11);
         rx_pkt(2'd3, 1'b1);
         pay_ok(2, 4'hA);
         send_ok(2'd3, 1'b0, 4'hA, 0, "R5");
      end
   endtask

   task automatic t_ignore_wrong();
      do_reset();
      pick(1'b1);
      send_ok(2'd0, 1'b1, 4'h1, 0, "R2");
      repeat (TO - 5) @(negedge clk);
      rx_pkt(2'd3, 1'b0);          // wrong type
      rx_pkt(2'd1, 1'b1);          // right type, wrong role
      repeat (2) @(negedge clk);
      chk(tx_req == 1'b0 && status == 4'h5, "R7", tx_req, 0);
      @(negedge clk);
      chk(tx_req == 1'b1 && tx_type == 2'd0, "R7", tx_type, 0);
   endtask

   task automatic t_resend();
      do_reset();
      pick(1'b1);
      send_ok(2'd0, 1'b1, 4'h1, 0, "R2");
      expect_resend(2'd0, "R8");
      send_ok(2'd0, 1'b1, 4'h1, 0, "R8");
      rx_pkt(2'd1, 1'b0);
      send_ok(2'd2, 1'b1, 4'h3, 0, "R2");
      rx_pkt(2'd2, 1'b0);
      pay_ok(0, 4'h8);
      send_ok(2'd3, 1'b1, 4'h8, 0, "R5");
      expect_resend(2'd3, "R8");   // data resend with no payload request
      send_ok(2'd3, 1'b1, 4'h8, 0, "R8");
      chk(status == 4'h9, "R8", status, 9);
   endtask

   task automatic t_loss_clear();
      do_reset();
      pick(1'b1);
      send_ok(2'd0, 1'b1, 4'h1, 0, "R2");
      for (int i = 0; i < LOSS - 1; i++) begin
         expect_resend(2'd0, "R10");
         send_ok(2'd0, 1'b1, 4'h1, 0, "R10");
      end
      rx_pkt(2'd1, 1'b0);
      send_ok(2'd2, 1'b1, 4'h3, 0, "R2");
      for (int i = 0; i < LOSS - 1; i++) begin
         expect_resend(2'd2, "R10");
         send_ok(2'd2, 1'b1, 4'h3, 0, "R10");
      end
      chk(status == 4'h5, "R10", status, 5);
      rx_pkt(2'd2, 1'b0);
      chk(pay_req == 1'b1 && status == 4'h8, "R10", status, 8);
   endtask

   task automatic t_collision();
      do_reset();
      pick(1'b1);
      send_ok(2'd0, 1'b1, 4'h1, 0, "R2");
      repeat (TO - 1) @(negedge clk);
      rx_pkt(2'd1, 1'b0);          // lands on the expiry edge
      chk(tx_req == 1'b1 && tx_type == 2'd2, "R11", tx_type, 2);
   endtask

   task automatic t_dead();
      do_reset();
      pick(1'b0);
      repeat (LOSS * TO - 1) @(negedge clk);
      chk(status == 4'h6, "R9", status, 6);
      @(negedge clk);
      chk(status == 4'hF, "R9", status, 15);
      chk(!tx_req && !pay_req, "R9", tx_req, 0);
      rx_pkt(2'd0, 1'b1);
      pick(1'b1);
      repeat (3) @(negedge clk);
      chk(status == 4'hF && !tx_req, "R9", status, 15);
      do_reset();
      chk(status == 4'h0, "R9", status, 0);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset_idle();
      t_master();
      t_slave();
      t_ignore_wrong();
      t_resend();
      t_loss_clear();
      t_collision();
      t_dead();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule